// File: doc/BRIEF.md
# Shifted-Operand ALU Datapath

This block is the arithmetic core of a small signal-processing engine. It holds a register file of 40 words, each 25 bits of two's complement data. Each instruction cycle, it reads two words. The source word passes through a one-cycle barrel shifter. The shifted value and the unshifted destination word then meet in an ALU. When the instruction is enabled, the ALU output is written back over the destination word at the next clock edge.

The shifter is lopsided. It shifts right by any amount from zero to thirteen places, or left by one or two places. The ALU offers plain and saturating arithmetic, absolute value, absolute-add, bitwise operations and a clamp to full scale. A debug port can preload any word and read it back. A sequencer or a test fixture uses this port to set coefficients and observe results.

Top module: `shift_alu_dp`

## Requirements
- R1: While `rst_n` is low, every word of the register file is cleared to zero. After reset, all 40 words read back as zero and `ovf` is low.
- R2: `dbg_rdata` shows the word at `dbg_addr` without delay. With `dbg_we` high, `dbg_wdata` is stored there at the clock edge. Addresses 40 to 63 read as zero, and writes to them are ignored.
- R3: Shift code values 0 to 13 shift the source right by that many places. Code 14 shifts it left by one place, and code 15 shifts it left by two places.
- R4: Right shifts copy the sign bit into the vacated top bits. Left shifts drop the bits pushed out of the top and fill the bottom with zeros.
- R5: With `en` high, the `result` value is stored into the destination word at the clock edge. With `en` low, the register file is left unchanged.
- R6: Opcode 1 computes destination plus shifted source. Opcode 2 computes destination minus shifted source. Both clamp to +16777215 or -16777216 when the true result is out of range, and raise `ovf` in that case.
- R7: Opcode 3 gives the absolute value of the shifted source. The most negative value clamps to +16777215 and raises `ovf`.
- R8: Opcode 4 adds the absolute value of the shifted source to the destination. An out-of-range sum clamps to the nearest limit and raises `ovf`.
- R9: Opcode 0 passes the shifted source through. Opcode 5 gives the bitwise XOR of destination and shifted source, and opcode 6 gives their bitwise AND. None of these three raises `ovf`.
- R10: Opcode 7 gives -16777216 when the shifted source is negative, and +16777215 otherwise. It never raises `ovf`.
- R11: When a debug write and an instruction write hit the same word in the same cycle, the debug data is kept. An instruction whose destination is 40 or above changes nothing.
- R12: `ovf` is low whenever `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Execute the presented instruction this cycle |
| src_addr | input | 6 | Address of the word routed through the shifter |
| dst_addr | input | 6 | Address of the destination word (ALU input and write target) |
| shift_code | input | 4 | Shift amount and direction |
| alu_op | input | 3 | ALU opcode |
| result | output | 25 | Write-back value for the current instruction |
| ovf | output | 1 | Saturation occurred in the current instruction |
| dbg_we | input | 1 | Debug write strobe |
| dbg_addr | input | 6 | Debug address |
| dbg_wdata | input | 25 | Debug write data |
| dbg_rdata | output | 25 | Word at the debug address |

## Verification
Some rules are checked by the assertions on every cycle:
- a raised `ovf` always pairs with a full-scale `result`;
- `ovf` stays low for the bitwise, load and clamp opcodes, and whenever `en` is low;
- the clamp opcode only ever yields one of the two limits;
- a committed instruction or debug write lands in the addressed word one edge later.

The exact arithmetic is shown only by the bench's sweep. This covers the shift amounts, the sign handling of right shifts, the truncation of left shifts, and the precise boundary where each operation begins to saturate. The sweep runs every shift code and opcode over corner-valued operands. It compares both the combinational result and the word read back through the debug port. Directed cases cover reset, out-of-range addresses and write priority.

// File: rtl/shift_alu_dp.sv
module shift_alu_dp #(
  parameter int W       = 25,
  parameter int DEPTH   = 40,
  parameter int MAX_RSH = 13,
  parameter int MAX_LSH = 2
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     en,
  input  logic [$clog2(DEPTH)-1:0]                 src_addr,
  input  logic [$clog2(DEPTH)-1:0]                 dst_addr,
  input  logic [$clog2(MAX_RSH+1+MAX_LSH)-1:0]     shift_code,
  input  logic [2:0]                               alu_op,
  output logic [W-1:0]                             result,
  output logic                                     ovf,
  input  logic                                     dbg_we,
  input  logic [$clog2(DEPTH)-1:0]                 dbg_addr,
  input  logic [W-1:0]                             dbg_wdata,
  output logic [W-1:0]                             dbg_rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int XW = W + 2;
  localparam logic [W-1:0] POS_FS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_FS = {1'b1, {(W-1){1'b0}}};

  localparam logic [2:0] OP_PASS = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2, OP_ABS = 3'd3,
                         OP_ABA  = 3'd4, OP_XOR = 3'd5, OP_AND = 3'd6, OP_LIM = 3'd7;

  logic signed [W-1:0] mem [DEPTH];

  wire src_ok = src_addr < AW'(DEPTH);
  wire dst_ok = dst_addr < AW'(DEPTH);
  wire dbg_ok = dbg_addr < AW'(DEPTH);

  logic signed [W-1:0] opa, opd, sh;
  assign opa       = src_ok ? mem[src_addr] : '0;
  assign opd       = dst_ok ? mem[dst_addr] : '0;
  assign dbg_rdata = dbg_ok ? mem[dbg_addr] : '0;

  always_comb begin
    if (int'(shift_code) <= MAX_RSH) sh = opa >>> shift_code;
    else                             sh = opa <<< (int'(shift_code) - MAX_RSH);
  end

  logic signed [XW-1:0] xd, xs, xabs, xsum;
  logic                 arith, sat;
  assign xd   = {{2{opd[W-1]}}, opd};
  assign xs   = {{2{sh[W-1]}}, sh};
  assign xabs = xs[XW-1] ? -xs : xs;

  always_comb begin
    arith = 1'b1;
    case (alu_op)
      OP_ADD:  xsum = xd + xs;
      OP_SUB:  xsum = xd - xs;
      OP_ABS:  xsum = xabs;
      OP_ABA:  xsum = xd + xabs;
      default: begin xsum = '0; arith = 1'b0; end
    endcase
  end

  assign sat = !((&xsum[XW-1:W-1]) || !(|xsum[XW-1:W-1]));

  always_comb begin
    case (alu_op)
      OP_PASS: result = sh;
      OP_XOR:  result = opd ^ sh;
      OP_AND:  result = opd & sh;
      OP_LIM:  result = sh[W-1] ? NEG_FS : POS_FS;
      default: result = sat ? (xsum[XW-1] ? NEG_FS : POS_FS) : xsum[W-1:0];
    endcase
  end

  assign ovf = en && arith && sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (en && dst_ok)     mem[dst_addr] <= result;
      if (dbg_we && dbg_ok) mem[dbg_addr] <= dbg_wdata;
    end
  end

  // R5: committed instruction lands in the destination word
  a_r5_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dst_ok && !(dbg_we && dbg_addr == dst_addr)) |=> mem[$past(dst_addr)] == $past(result));

  // R2: debug write lands in the addressed word
  a_r2_dbg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_we && dbg_ok) |=> mem[$past(dbg_addr)] == $past(dbg_wdata));

  // R6/R7/R8: saturation yields a full-scale value
  a_r6_sat_fullscale: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (result == POS_FS || result == NEG_FS));

  // R9: bitwise and pass opcodes never flag
  a_r9_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == OP_PASS || alu_op == OP_XOR || alu_op == OP_AND) |-> !ovf);

  // R10: clamp opcode gives a limit without flag
  a_r10_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == OP_LIM) |-> ((result == POS_FS || result == NEG_FS) && !ovf));

  // R12: no flag when idle
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !ovf);
endmodule

// File: tb/test_shift_alu_dp.sv
module test_shift_alu_dp;
  localparam longint MASK = (64'sd1 << 25) - 1;
  localparam longint SGN  = 64'sd1 << 24;
  localparam longint PMAX = SGN - 1;
  localparam longint NMIN = -SGN;

  logic clk = 0, rst_n = 0, en = 0, dbg_we = 0;
  logic [5:0] src_addr = 0, dst_addr = 0, dbg_addr = 0;
  logic [3:0] shift_code = 0;
  logic [2:0] alu_op = 0;
  logic [24:0] dbg_wdata = 0, result, dbg_rdata;
  logic ovf;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shift_alu_dp i_shift_alu_dp (
    .clk(clk), .rst_n(rst_n), .en(en), .src_addr(src_addr), .dst_addr(dst_addr),
    .shift_code(shift_code), .alu_op(alu_op), .result(result), .ovf(ovf),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata));

  function automatic longint sx(longint x);
    return ((x & MASK) ^ SGN) - SGN;
  endfunction

  // R3 R4 model of the shifter
  function automatic longint shf(longint v, int code);
    if (code <= 13) return sx(v) >>> code;
    return sx(sx(v) << (code - 13));
  endfunction

  function automatic longint clip(longint x, output bit f);
    f = (x > PMAX) || (x < NMIN);
    if (x > PMAX) return PMAX;
    if (x < NMIN) return NMIN;
    return x;
  endfunction

  function automatic longint model(longint s, longint d, int code, int op, output bit f);
    longint v = shf(s, code);
    longint dd = sx(d);
    longint av = (v < 0) ? -v : v;
    f = 0;
    case (op)
      0: return v;
      1: return clip(dd + v, f);
      2: return clip(dd - v, f);
      3: return clip(av, f);
      4: return clip(dd + av, f);
      5: return sx((dd ^ v) & MASK);
      6: return sx((dd & v) & MASK);
      default: return (v < 0) ? NMIN : PMAX;
    endcase
  endfunction

  function automatic string tag(int op);
    case (op)
      1, 2: return "R6";
      3: return "R7";
      4: return "R8";
      7: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic dwr(int a, longint v);
    @(negedge clk);
    dbg_we = 1; dbg_addr = 6'(a); dbg_wdata = 25'(v);
    @(negedge clk);
    dbg_we = 0;
  endtask

  task automatic drd(int a, string req, longint exp);
    @(negedge clk);
    dbg_addr = 6'(a);
    #1 chk(req, sx(longint'(dbg_rdata)), exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  longint vals[8] = '{0, 1, -1, PMAX, NMIN, 12345, -987654, 5592405};

  initial begin
    bit ef;
    longint ex;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 40; a++) begin
      dbg_addr = 6'(a);
      #1 chk("R1 word", sx(longint'(dbg_rdata)), 0);
    end
    chk("R1 ovf", ovf, 0);
    rst_n = 1;

    // R2: out-of-range debug access
    dwr(45, 777);
    drd(45, "R2 out of range", 0);
    dwr(39, -4242);
    drd(39, "R2 last word", -4242);

    // main sweep: R3 R4 R5 R6 R7 R8 R9 R10
    for (int si = 0; si < 8; si++)
      for (int di = 0; di < 8; di++)
        for (int code = 0; code < 16; code++)
          for (int op = 0; op < 8; op++) begin
            dwr(5, vals[si]);
            dbg_we = 1; dbg_addr = 30; dbg_wdata = 25'(vals[di]);
            @(negedge clk);
            dbg_we = 0;
            en = 1; src_addr = 5; dst_addr = 30; shift_code = 4'(code); alu_op = 3'(op);
            ex = model(vals[si], vals[di], code, op, ef);
            #1;
            chk({tag(op), " result (shift R3 R4)"}, sx(longint'(result)), ex);
            chk({tag(op), " ovf"}, ovf, ef);
            @(negedge clk);
            en = 0; dbg_addr = 30;
            #1 chk("R5 stored", sx(longint'(dbg_rdata)), ex);
          end

    // R5 R12: disabled instruction
    dwr(7, PMAX);
    dwr(8, PMAX);
    @(negedge clk);
    en = 0; src_addr = 7; dst_addr = 8; shift_code = 0; alu_op = 1;
    #1 chk("R12 ovf idle", ovf, 0);
    drd(8, "R5 no write when idle", PMAX);

    // R7: same address as source and destination, most negative
    dwr(9, NMIN);
    @(negedge clk);
    en = 1; src_addr = 9; dst_addr = 9; shift_code = 0; alu_op = 3;
    #1 chk("R7 ovf abs min", ovf, 1);
    @(negedge clk);
    en = 0;
    drd(9, "R7 abs min stored", PMAX);

    // R11: debug write wins on collision
    dwr(10, 100);
    @(negedge clk);
    en = 1; src_addr = 10; dst_addr = 10; shift_code = 0; alu_op = 1;
    dbg_we = 1; dbg_addr = 10; dbg_wdata = 25'(-55);
    @(negedge clk);
    en = 0; dbg_we = 0;
    drd(10, "R11 debug priority", -55);

    // R11: out-of-range destination leaves words alone
    dwr(11, 321);
    @(negedge clk);
    en = 1; src_addr = 11; dst_addr = 50; shift_code = 0; alu_op = 0;
    @(negedge clk);
    en = 0;
    drd(50, "R11 oor dst read", 0);
    drd(11, "R11 src intact", 321);
    drd(39, "R11 last word intact", -4242);

    finish_run();
  end
endmodule